// File: doc/BRIEF.md
# Receive Port Error Aggregator

This block sits beside the receive side of a multi-lane serial link and folds every physical-layer receive fault into a single correctable error. Each lane presents a 3-bit receive status code, a flag meaning a control symbol arrived on a lane where it does not belong, and a flag saying the lane is in the active link state (L0). A single shared flag reports that the multilane deskew FIFO overflowed. The block decodes the codes, counts coding faults only on lanes that are active, and merges all causes. It reports them as a one-cycle error pulse, a sticky bit per cause and a sticky mask of offending lanes. Software clears the sticky state through a synchronous clear input.

A two-state machine tracks whether anything is recorded. The states are ST_CLEAN (no sticky bit set) and ST_FLAGGED (at least one sticky bit set). The transition CLEAN to FLAGGED fires on any cause in the current cycle. The transition FLAGGED to CLEAN fires on a clear with no cause in the same cycle. In all other cases each state holds. All outputs are registered, so they reflect the inputs of the previous clock edge.

Top module: `rx_port_err_agg`

## Requirements
- R1: On a lane in L0, status code 3'b100 sets cause bit 0 (coding error), 3'b101 sets bit 1 (elastic buffer overflow), 3'b110 sets bit 2 (elastic buffer underflow) and 3'b111 sets bit 3 (disparity error), one cycle after the code is presented.
- R2: Status codes 3'b000 to 3'b011 set no cause bit, no lane bit and no pulse.
- R3: A lane whose L0 flag is low contributes no coding cause and no lane bit from its status code.
- R4: The shared deskew overflow flag sets cause bit 4 and no lane bit.
- R5: A misplaced control symbol on a lane sets cause bit 5 and that lane's mask bit, whatever the lane's link state.
- R6: err_pulse is high in the cycle after each cycle that holds at least one cause, and low otherwise.
- R7: The lane mask bit of a lane is set when that lane had a gated coding error or a misplaced control symbol.
- R8: Sticky cause bits and lane mask bits never clear except through clr.
- R9: clr empties the sticky cause bits and lane mask, except that causes present in the same cycle are recorded.
- R10: After reset, err_pulse, all cause bits and the lane mask are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_code | input | 3*LANES | Per-lane receive status code, lane n in bits [3n+2:3n] |
| lane_in_l0 | input | LANES | Lane is in active link state L0 |
| wrong_lane_sym | input | LANES | Control symbol seen on the wrong lane |
| deskew_ovf | input | 1 | Multilane deskew FIFO overflow |
| clr | input | 1 | Synchronous clear of sticky state |
| err_pulse | output | 1 | Correctable receive port error, one cycle per cause cycle |
| cause_sticky | output | 6 | Sticky cause bits, order as in R1, R4, R5 |
| lane_sticky | output | LANES | Sticky mask of offending lanes |

## Verification
The embedded properties assume that clr and all fault inputs are defined binary values on every clock edge once reset is released. They also assume the outputs depend only on the previous edge's inputs. The bench drives every input on the falling edge from a single process, so it never changes an input near a rising edge. It mixes directed patterns for each code, link state and clear overlap with random traffic where clear is rare, so the sticky hold and the clear interaction are both exercised.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
    localparam int NUM_CAUSES = 6;
    localparam int CODE_W     = 3;
    localparam int CODING_N   = 4;
    localparam int C_DESKEW   = 4;
    localparam int C_WRONGSYM = 5;

    typedef enum logic {
        ST_CLEAN   = 1'b0,
        ST_FLAGGED = 1'b1
    } rpe_state_t;
endpackage

// File: rtl/rpe_lane_decode.sv
module rpe_lane_decode
    import rpe_pkg::*;
(
    input  logic [CODE_W-1:0]   code,
    input  logic                in_l0,
    input  logic                wrong_sym,
    output logic [CODING_N-1:0] coding_hit,
    output logic                sym_hit,
    output logic                lane_hit
);
    always_comb begin
        coding_hit = '0;
        if (in_l0) begin
            unique case (code)
                3'b100:  coding_hit[0] = 1'b1;
                3'b101:  coding_hit[1] = 1'b1;
                3'b110:  coding_hit[2] = 1'b1;
                3'b111:  coding_hit[3] = 1'b1;
                default: coding_hit    = '0;
            endcase
        end
    end

    assign sym_hit  = wrong_sym;
    assign lane_hit = (|coding_hit) | wrong_sym;
endmodule

// File: rtl/rpe_cause_merge.sv
module rpe_cause_merge
    import rpe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*CODING_N-1:0] lane_coding,
    input  logic [LANES-1:0]          lane_sym,
    input  logic [LANES-1:0]          lane_hit,
    input  logic                      deskew_ovf,
    output logic [NUM_CAUSES-1:0]     cause_now,
    output logic [LANES-1:0]          lanes_now,
    output logic                      any_now
);
    logic [CODING_N-1:0] coding_or;

    always_comb begin
        coding_or = '0;
        for (int l = 0; l < LANES; l++) begin
            coding_or = coding_or | lane_coding[l*CODING_N +: CODING_N];
        end
        cause_now                   = '0;
        cause_now[CODING_N-1:0]     = coding_or;
        cause_now[C_DESKEW]         = deskew_ovf;
        cause_now[C_WRONGSYM]       = |lane_sym;
    end

    assign lanes_now = lane_hit;
    assign any_now   = |cause_now;
endmodule

// File: rtl/rpe_sticky_fsm.sv
module rpe_sticky_fsm
    import rpe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic [NUM_CAUSES-1:0] cause_now,
    input  logic [LANES-1:0]      lanes_now,
    input  logic                  any_now,
    output logic                  err_pulse,
    output logic [NUM_CAUSES-1:0] cause_sticky,
    output logic [LANES-1:0]      lane_sticky
);
    rpe_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CLEAN:   if (any_now)         state_nxt = ST_FLAGGED;
            ST_FLAGGED: if (clr && !any_now) state_nxt = ST_CLEAN;
            default:                         state_nxt = ST_CLEAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAN;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_pulse    <= 1'b0;
            cause_sticky <= '0;
            lane_sticky  <= '0;
        end else begin
            err_pulse    <= any_now;
            cause_sticky <= (clr ? '0 : cause_sticky) | cause_now;
            lane_sticky  <= (clr ? '0 : lane_sticky)  | lanes_now;
        end
    end

    // R6
    pulse_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (state == ST_FLAGGED));

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cause_sticky & $past(cause_sticky)) == $past(cause_sticky)
                  && (lane_sticky & $past(lane_sticky)) == $past(lane_sticky)));

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !any_now) |=> (cause_sticky == '0 && lane_sticky == '0 && state == ST_CLEAN));

    // R10
    clean_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAN) |-> (cause_sticky == '0 && lane_sticky == '0));
endmodule

// File: rtl/rx_port_err_agg.sv
module rx_port_err_agg
    import rpe_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*CODE_W-1:0] rx_code,
    input  logic [LANES-1:0]        lane_in_l0,
    input  logic [LANES-1:0]        wrong_lane_sym,
    input  logic                    deskew_ovf,
    input  logic                    clr,
    output logic                    err_pulse,
    output logic [NUM_CAUSES-1:0]   cause_sticky,
    output logic [LANES-1:0]        lane_sticky
);
    localparam int CODING_W = LANES * CODING_N;

    logic [CODING_W-1:0]   lane_coding;
    logic [LANES-1:0]      lane_sym;
    logic [LANES-1:0]      lane_hit;
    logic [NUM_CAUSES-1:0] cause_now;
    logic [LANES-1:0]      lanes_now;
    logic                  any_now;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rpe_lane_decode u_dec (
            .code       (rx_code[g*CODE_W +: CODE_W]),
            .in_l0      (lane_in_l0[g]),
            .wrong_sym  (wrong_lane_sym[g]),
            .coding_hit (lane_coding[g*CODING_N +: CODING_N]),
            .sym_hit    (lane_sym[g]),
            .lane_hit   (lane_hit[g])
        );
    end

    rpe_cause_merge #(.LANES(LANES)) u_merge (
        .lane_coding (lane_coding),
        .lane_sym    (lane_sym),
        .lane_hit    (lane_hit),
        .deskew_ovf  (deskew_ovf),
        .cause_now   (cause_now),
        .lanes_now   (lanes_now),
        .any_now     (any_now)
    );

    rpe_sticky_fsm #(.LANES(LANES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .cause_now    (cause_now),
        .lanes_now    (lanes_now),
        .any_now      (any_now),
        .err_pulse    (err_pulse),
        .cause_sticky (cause_sticky),
        .lane_sticky  (lane_sticky)
    );

    // R7
    mask_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_sticky) |-> ((|cause_sticky[CODING_N-1:0]) || cause_sticky[C_WRONGSYM]));

    // R4
    deskew_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deskew_ovf && !clr && lane_hit == '0) |=> (lane_sticky == $past(lane_sticky)));

    // R6
    pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_code == '0 && wrong_lane_sym == '0 && !deskew_ovf) |=> !err_pulse);
endmodule

// File: tb/sim_rx_port_err_agg.sv
module sim_rx_port_err_agg;
    localparam int LANES = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [LANES*3-1:0] rx_code = '0;
    logic [LANES-1:0]   lane_in_l0 = '0;
    logic [LANES-1:0]   wrong_lane_sym = '0;
    logic               deskew_ovf = 1'b0;
    logic               clr = 1'b0;
    logic               err_pulse;
    logic [5:0]         cause_sticky;
    logic [LANES-1:0]   lane_sticky;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R10";

    logic             e_pulse = 1'b0;
    logic [5:0]       e_cause = '0;
    logic [LANES-1:0] e_lane  = '0;

    always #5 clk = ~clk;

    rx_port_err_agg #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_code(rx_code), .lane_in_l0(lane_in_l0),
        .wrong_lane_sym(wrong_lane_sym), .deskew_ovf(deskew_ovf), .clr(clr),
        .err_pulse(err_pulse), .cause_sticky(cause_sticky), .lane_sticky(lane_sticky)
    );

    task automatic compare();
        checks++;
        if (err_pulse !== e_pulse || cause_sticky !== e_cause || lane_sticky !== e_lane) begin
            errors++;
            $display("FAIL %s t=%0t pulse %b/%b cause %b/%b lanes %b/%b (actual/expected)",
                     tag, $time, err_pulse, e_pulse, cause_sticky, e_cause, lane_sticky, e_lane);
        end
    endtask

    task automatic model();
        logic [5:0]       c = '0;
        logic [LANES-1:0] m = '0;
        for (int l = 0; l < LANES; l++) begin
            int code = int'(rx_code[l*3 +: 3]);
            if (lane_in_l0[l] && code >= 4) begin
                c[code - 4] = 1'b1;
                m[l] = 1'b1;
            end
            if (wrong_lane_sym[l]) begin
                c[5] = 1'b1;
                m[l] = 1'b1;
            end
        end
        if (deskew_ovf) c[4] = 1'b1;
        e_pulse = (c != '0);
        e_cause = (clr ? 6'b0 : e_cause) | c;
        e_lane  = (clr ? '0 : e_lane) | m;
    endtask

    // Apply one cycle of stimulus, then check after the edge that consumes it.
    task automatic step(input string t, input logic [LANES*3-1:0] code,
                        input logic [LANES-1:0] l0, input logic [LANES-1:0] ws,
                        input logic dk, input logic cl);
        rx_code = code; lane_in_l0 = l0; wrong_lane_sym = ws;
        deskew_ovf = dk; clr = cl;
        model();
        @(negedge clk);
        tag = t;
        compare();
    endtask

    task automatic idle(input string t);
        step(t, '0, '1, '0, 1'b0, 1'b0);
    endtask

    task automatic wipe();
        step("R9", '0, '0, '0, 1'b0, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tag = "R10";
        compare();
        rst_n = 1'b1;
        idle("R10");

        // R1: each coding code on a different active lane
        for (int k = 4; k < 8; k++) begin
            logic [LANES*3-1:0] cv = '0;
            cv[(k-4)*3 +: 3] = 3'(k);
            step("R1", cv, '1, '0, 1'b0, 1'b0);
            idle("R6");
            wipe();
        end
        // R2: harmless codes on every lane
        for (int k = 0; k < 4; k++) begin
            step("R2", {LANES{3'(k)}}, '1, '0, 1'b0, 1'b0);
        end
        idle("R2");
        // R3: error codes on lanes not in L0
        step("R3", {LANES{3'b111}}, 4'b0000, '0, 1'b0, 1'b0);
        step("R3", {3'b100, 3'b111, 3'b101, 3'b110}, 4'b0101, '0, 1'b0, 1'b0);
        idle("R3");
        wipe();
        // R4: deskew overflow alone
        step("R4", '0, '1, '0, 1'b1, 1'b0);
        idle("R4");
        wipe();
        // R5: misplaced symbol on an inactive lane
        step("R5", '0, '0, 4'b1000, 1'b0, 1'b0);
        step("R7", {3'b000, 3'b000, 3'b110, 3'b000}, 4'b0010, 4'b0001, 1'b0, 1'b0);
        // R8: sticky state holds over quiet cycles
        for (int k = 0; k < 5; k++) idle("R8");
        // R9: clear together with a new cause keeps the new cause
        step("R9", '0, '1, 4'b0100, 1'b1, 1'b1);
        idle("R9");
        wipe();
        idle("R9");
        // R6: back-to-back cause cycles give back-to-back pulses
        step("R6", {LANES{3'b100}}, '1, '0, 1'b0, 1'b0);
        step("R6", '0, '0, '0, 1'b1, 1'b0);
        idle("R6");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [LANES*3-1:0] cv;
            logic [LANES-1:0]   lv, wv;
            logic               dv, cl;
            for (int l = 0; l < LANES; l++) begin
                int r = int'($urandom_range(0, 9));
                cv[l*3 +: 3] = (r < 7) ? 3'($urandom_range(0, 3)) : 3'($urandom_range(4, 7));
                lv[l] = ($urandom_range(0, 3) != 0);
                wv[l] = ($urandom_range(0, 29) == 0);
            end
            dv = ($urandom_range(0, 39) == 0);
            cl = ($urandom_range(0, 19) == 0);
            step("R8", cv, lv, wv, dv, cl);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule